// File: doc/BRIEF.md
# Power-Down Recovery Sequencer

This block brings a combined Ethernet MAC and PHY back from low-power mode in a fixed order. A wake request seen while the block is idle starts a walk through a chain of steps. The chain turns on the PHY-derived clocks, clears the PHY power-down control and then releases PHY isolation. It then waits a settling time that is set in clock cycles, issues a one-cycle reset to the buffer manager, enables the transmitter and then the receiver, and finally raises a ready flag.

A sleep request has priority over everything else. In any step it sends the sequencer back to idle and returns every output to its low-power value. Other logic drives the wake and sleep requests and reacts to the outputs. The settling time defaults to 500 ms at 125 MHz. A short value can be set for simulation.

Top module: `pwr_recovery_seq`

## Requirements
- R1: During and right after reset, the outputs take their idle values: clkEn=0, phyPdn=1, phyIso=1, mmuRst=0, txEn=0, rxEn=0, ready=0.
- R2: When wakeReq=1 and sleepReq=0 are sampled at a clock edge while the block is idle, clkEn rises one cycle after that edge (at the second edge).
- R3: phyPdn falls one cycle after clkEn rises, and phyIso falls one cycle after phyPdn falls.
- R4: The mmuRst pulse rises exactly SettleCycles+1 cycles after phyIso falls.
- R5: mmuRst is high for exactly one cycle in each wake sequence.
- R6: txEn rises in the cycle after the mmuRst pulse, and rxEn rises one cycle after txEn.
- R7: ready rises one cycle after rxEn and stays high until a sleep request. ready is never high unless txEn and rxEn are both high.
- R8: When sleepReq=1 is sampled at any edge, every output holds its R1 idle value after that edge. This holds in any step and even if wakeReq is high at the same time.
- R9: wakeReq has no effect while a sequence is in progress or complete. The outputs follow the same timing as if it were low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wakeReq | input | 1 | Request to leave low-power mode (acted on only when idle) |
| sleepReq | input | 1 | Request to return to low-power mode (highest priority) |
| clkEn | output | 1 | Enable for the RX, TX and core MAC clocks |
| phyPdn | output | 1 | PHY power-down control, 1 = powered down |
| phyIso | output | 1 | PHY isolate control, 1 = isolated |
| mmuRst | output | 1 | One-cycle reset pulse to the buffer manager |
| txEn | output | 1 | Transmitter enable |
| rxEn | output | 1 | Receiver enable |
| ready | output | 1 | Block is fully back in normal operation |

## Verification
The bench builds the sequencer with SettleCycles set to 4 in place of the default of about 62.5 million cycles. This puts the full wake sequence within a few dozen cycles, so every output edge can be compared cycle by cycle against a timing model. The short wait also lets the bench send sleep requests in several steps: during the clock-enable step, in the middle of the settle wait, and after ready. It also checks a wake and a sleep that arrive together, and wake requests repeated after the block is ready.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    stIdle,
    stClkOn,
    stPhyOn,
    stIsoOff,
    stSettle,
    stMmuClr,
    stTxOn,
    stRxOn,
    stReady
  } seqState_t;

  typedef struct packed {
    logic clearAll;
    logic setClk;
    logic clrPdn;
    logic clrIso;
    logic countEn;
    logic pulseMmu;
    logic setTx;
    logic setRx;
    logic setReady;
  } seqStrobes_t;

endpackage

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wakeReq,
  input  logic        sleepReq,
  input  logic        waitDone,
  output seqStrobes_t strobes
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= stIdle;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    if (sleepReq) begin
      stateNext = stIdle;
    end else begin
      unique case (state)
        stIdle:   if (wakeReq) stateNext = stClkOn;
        stClkOn:  stateNext = stPhyOn;
        stPhyOn:  stateNext = stIsoOff;
        stIsoOff: stateNext = stSettle;
        stSettle: if (waitDone) stateNext = stMmuClr;
        stMmuClr: stateNext = stTxOn;
        stTxOn:   stateNext = stRxOn;
        stRxOn:   stateNext = stReady;
        stReady:  stateNext = stReady;
        default:  stateNext = stIdle;
      endcase
    end
  end

  // One strobe per step; a sleep request masks all of them but clearAll.
  always_comb begin
    strobes = '0;
    if (sleepReq) begin
      strobes.clearAll = 1'b1;
    end else begin
      strobes.setClk   = (state == stClkOn);
      strobes.clrPdn   = (state == stPhyOn);
      strobes.clrIso   = (state == stIsoOff);
      strobes.countEn  = (state == stSettle);
      strobes.pulseMmu = (state == stMmuClr);
      strobes.setTx    = (state == stTxOn);
      strobes.setRx    = (state == stRxOn);
      strobes.setReady = (state == stReady);
    end
  end

  // R9: a request arriving mid-sequence does not pull the machine back to the first step
  p_wake_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != stIdle && !sleepReq) |=> (state != stClkOn));

  // R8: sleep always lands in idle
  p_sleep_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (state == stIdle));

endmodule

// File: rtl/pwr_seq_dpath.sv
module pwr_seq_dpath
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SettleCycles = 62_500_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t strobes,
  output logic        waitDone,
  output logic        clkEn,
  output logic        phyPdn,
  output logic        phyIso,
  output logic        mmuRst,
  output logic        txEn,
  output logic        rxEn,
  output logic        ready
);

  localparam int unsigned CntW = (SettleCycles > 1) ? $clog2(SettleCycles) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(SettleCycles - 1);

  logic [CntW-1:0] settleCnt;

  assign waitDone = strobes.countEn && (settleCnt == CntLast);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrIso) settleCnt <= '0;
    else if (strobes.countEn && !waitDone) settleCnt <= settleCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clearAll) begin
      clkEn  <= 1'b0;
      phyPdn <= 1'b1;
      phyIso <= 1'b1;
      mmuRst <= 1'b0;
      txEn   <= 1'b0;
      rxEn   <= 1'b0;
      ready  <= 1'b0;
    end else begin
      if (strobes.setClk)   clkEn  <= 1'b1;
      if (strobes.clrPdn)   phyPdn <= 1'b0;
      if (strobes.clrIso)   phyIso <= 1'b0;
      mmuRst <= strobes.pulseMmu;
      if (strobes.setTx)    txEn   <= 1'b1;
      if (strobes.setRx)    rxEn   <= 1'b1;
      if (strobes.setReady) ready  <= 1'b1;
    end
  end

  // R3: power-down clears only with clocks on; isolation clears only after power-down
  p_pdn_after_clk_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyPdn) |-> clkEn);
  p_iso_after_pdn_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyIso) |-> !phyPdn);

  // R4: buffer-manager reset only once the PHY has left isolation
  p_mmu_after_iso_r4: assert property (@(posedge clk) disable iff (!rstN)
    mmuRst |-> (!phyIso && !txEn));

  // R5: single-cycle pulse
  p_mmu_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    mmuRst |=> !mmuRst);

  // R6: transmitter follows the pulse, receiver follows the transmitter
  p_tx_after_mmu_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEn) |-> $past(mmuRst));
  p_rx_after_tx_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxEn) |-> $past(txEn));

  // R7: ready implies both directions enabled
  p_ready_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (txEn && rxEn));

endmodule

// File: rtl/pwr_recovery_seq.sv
module pwr_recovery_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned SettleCycles = 62_500_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic wakeReq,
  input  logic sleepReq,
  output logic clkEn,
  output logic phyPdn,
  output logic phyIso,
  output logic mmuRst,
  output logic txEn,
  output logic rxEn,
  output logic ready
);

  seqStrobes_t strobes;
  logic        waitDone;

  pwr_seq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wakeReq  (wakeReq),
    .sleepReq (sleepReq),
    .waitDone (waitDone),
    .strobes  (strobes)
  );

  pwr_seq_dpath #(.SettleCycles(SettleCycles)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .waitDone (waitDone),
    .clkEn    (clkEn),
    .phyPdn   (phyPdn),
    .phyIso   (phyIso),
    .mmuRst   (mmuRst),
    .txEn     (txEn),
    .rxEn     (rxEn),
    .ready    (ready)
  );

  // R8: a sleep request returns every output to its low-power value
  p_sleep_drops_r8: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (!clkEn && phyPdn && phyIso && !mmuRst && !txEn && !rxEn && !ready));

endmodule

// File: tb/tb_pwr_recovery_seq.sv
`timescale 1ns/1ps
module tb_pwr_recovery_seq;

  localparam int Settle = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wakeReq = 1'b0;
  logic sleepReq = 1'b0;
  logic clkEn, phyPdn, phyIso, mmuRst, txEn, rxEn, ready;

  always #4 clk = ~clk;

  pwr_recovery_seq #(.SettleCycles(Settle)) dut (
    .clk(clk), .rstN(rstN), .wakeReq(wakeReq), .sleepReq(sleepReq),
    .clkEn(clkEn), .phyPdn(phyPdn), .phyIso(phyIso), .mmuRst(mmuRst),
    .txEn(txEn), .rxEn(rxEn), .ready(ready)
  );

  logic [6:0] expQ[$];
  string      tagQ[$];
  int applied = 0;
  int miscomp = 0;
  int t = -1;     // edges since the accepted wake edge, -1 when idle
  bit done = 1'b0;

  // Output vector order: {clkEn, phyPdn, phyIso, mmuRst, txEn, rxEn, ready}
  function automatic logic [6:0] expVec(int tt);
    if (tt < 0) return 7'b0110000;
    return {tt >= 1, !(tt >= 2), !(tt >= 3), tt == Settle + 4,
            tt >= Settle + 5, tt >= Settle + 6, tt >= Settle + 7};
  endfunction

  task automatic step(input logic w, input logic s, input string tag);
    @(negedge clk);
    wakeReq  = w;
    sleepReq = s;
    @(posedge clk);
    if (s) t = -1;
    else if (t < 0 && w) t = 0;
    else if (t >= 0 && t < 1000) t++;
    #1;
    expQ.push_back(expVec(t));
    tagQ.push_back(tag);
  endtask

  // Monitor: compare one expected vector per clock, sampled mid-cycle
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      logic [6:0] e;
      logic [6:0] act;
      string tg;
      e   = expQ.pop_front();
      tg  = tagQ.pop_front();
      act = {clkEn, phyPdn, phyIso, mmuRst, txEn, rxEn, ready};
      applied++;
      if (act !== e) begin
        miscomp++;
        $display("FAIL %s: actual=%b expected=%b at %0t", tg, act, e, $time);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expQ.push_back(7'b0110000);
    tagQ.push_back("R1 reset values");
    @(negedge clk);
    rstN = 1'b1;

    // Full wake sequence
    step(1, 0, "R2 wake accepted");
    repeat (Settle + 10) step(0, 0, "R3 R4 R5 R6 R7 sequence timing");

    // Wake while ready has no effect
    repeat (3) step(1, 0, "R9 wake ignored while ready");

    // Sleep from ready
    step(0, 1, "R8 sleep from ready");
    repeat (2) step(0, 0, "R8 stays idle");

    // Simultaneous wake and sleep in idle
    step(1, 1, "R8 sleep beats wake");
    repeat (2) step(0, 0, "R8 idle after tie");

    // Sleep in the middle of the settle wait, with wake held (R9 too)
    step(1, 0, "R2 wake again");
    repeat (5) step(1, 0, "R9 wake held mid-sequence");
    step(0, 1, "R8 sleep during settle");
    repeat (2) step(0, 0, "R8 idle after settle abort");

    // Sleep right in the clock-enable step
    step(1, 0, "R2 wake for abort");
    step(0, 1, "R8 sleep during clock enable");
    repeat (2) step(0, 0, "R8 idle after early abort");

    // A clean restart completes in full
    step(1, 0, "R2 restart");
    repeat (Settle + 10) step(0, 0, "R4 R5 R6 R7 restart timing");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

endmodule